// File: doc/BRIEF.md
# Peripheral Interrupt Flag and Enable Controller

This block holds the interrupt flag and interrupt enable state of a classic 8-bit parallel/timer peripheral and drives one level-sensitive interrupt line toward the processor. Three event sources deliver single-cycle set pulses: a shift-register unit and two timers. The timers and the shift unit live in neighbouring blocks. This controller only sees their event pulses and watches the shared register bus so that it can clear the right flag when software touches the matching neighbour register.

The host reaches the block through a byte-wide register bus. The register index is taken from a 4-bit field of the byte address. Two indices belong to the block: the flag register and the enable register. Three further indices, the shift data register and the low bytes of the two timer counters, are owned by the neighbours. A read of any of those three clears the matching flag as a side effect. Read data is registered and appears one clock after the read strobe. The interrupt output is a flop that tracks the flag and enable state as it stands after each clock edge.

Top module: `vi_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all flags, all enables, `rd_data` and `irq` are zero.
- R2: A one-cycle pulse on `sr_evt`, `t2_evt` or `t1_evt` sets flag bit 2, bit 5 or bit 6 respectively. The flag is visible on the next flag-register read.
- R3: A write to index 13 (flag register) clears every flag bit 6..0 whose data bit is 1 and leaves the other flags unchanged.
- R4: A write to index 14 (enable register) with data bit 7 = 1 sets each enable bit 6..0 whose data bit is 1. With data bit 7 = 0, it clears each enable bit whose data bit is 1. Enable bits written as 0 keep their value in both cases.
- R5: A read of index 14 returns the enables in bits 6..0 and always returns bit 7 as 1.
- R6: A read of index 13 returns the flags in bits 6..0. Bit 7 is 1 exactly when some flag bit and its enable bit are both 1.
- R7: `irq` is 1 exactly when flag bit 2 or flag bit 6 is set together with its enable. Flag bit 5 never drives `irq`. `irq` follows the state produced by each clock edge.
- R8: A read of index 10 clears flag bit 2, a read of index 4 clears flag bit 6, and a read of index 8 clears flag bit 5. Writes to these three indices clear nothing.
- R9: The register index is `addr[12:9]`. Address bits 8..0 have no effect.
- R10: When a set pulse and a clearing access hit the same flag in the same cycle, the flag ends up set.
- R11: `rd_data` is registered. It holds the value read one cycle after `rd_en` and is zero after a cycle with no read or with a read of an index the block does not own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 13 | Byte address; bits 12..9 select the register |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| sr_evt | input | 1 | Shift-unit event pulse |
| t1_evt | input | 1 | Timer 1 event pulse |
| t2_evt | input | 1 | Timer 2 event pulse |
| irq | output | 1 | Level interrupt request |

## Verification
A directed sequence raises each source on its own, enables it through both polarities of the enable write, and confirms that `irq` follows the shift and timer-1 flags but never timer 2. This separates a correct output mask from one that ORs in every enabled flag. Further directed cases read the three side-effect addresses, write to the same addresses, write the flag register with partial masks, and collide a set pulse with a clearing read. These cases distinguish set priority, write-versus-read clearing, and per-bit write masking. A long random phase mixes all indices with random low address bits and random event pulses, so the summary bit, address decode and enable set/clear encoding are all compared against the model on every clock.

// File: rtl/vi_irq_pkg.sv
package vi_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int SRC_W    = DATA_W - 1;
  localparam int ADDR_W   = 13;
  localparam int IDX_LSB  = 9;
  localparam int IDX_W    = 4;

  // register indices decoded from the address field
  localparam logic [IDX_W-1:0] IDX_T1_LO  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_T2_LO  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_SHIFT  = 4'd10;
  localparam logic [IDX_W-1:0] IDX_FLAGS  = 4'd13;
  localparam logic [IDX_W-1:0] IDX_ENABLE = 4'd14;

  // flag bit positions
  localparam int BIT_SR = 2;
  localparam int BIT_T2 = 5;
  localparam int BIT_T1 = 6;

  // flags that are allowed to drive the interrupt line
  localparam logic [SRC_W-1:0] IRQ_MASK = SRC_W'((1 << BIT_SR) | (1 << BIT_T1));
endpackage

// File: rtl/vi_flag_bank.sv
module vi_flag_bank #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags,
  output logic [W-1:0] flags_nxt
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // set has priority over any clearing access in the same cycle
    always_comb begin
      if (set_vec[i])      flags_nxt[i] = 1'b1;
      else if (clr_vec[i]) flags_nxt[i] = 1'b0;
      else                 flags_nxt[i] = flags[i];
    end

    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= flags_nxt[i];
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> flags[i]); // R10
    AST_CLR_ONLY: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[i] && !set_vec[i]) |=> !flags[i]); // R3
  end
endmodule

// File: rtl/vi_enable_reg.sv
module vi_enable_reg #(
  parameter int DATA_W = 8,
  localparam int W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [W-1:0]      en,
  output logic [W-1:0]      en_nxt
);
  logic          set_mode;
  logic [W-1:0]  sel;

  assign set_mode = wr_data[DATA_W-1];
  assign sel      = wr_data[W-1:0];

  always_comb begin
    en_nxt = en;
    if (wr) begin
      if (set_mode) en_nxt = en | sel;
      else          en_nxt = en & ~sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en <= '0;
    else     en <= en_nxt;
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
    (wr && set_mode) |=> ((en & $past(sel)) == $past(sel))); // R4
  AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr && !set_mode) |=> ((en & $past(sel)) == '0)); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(en)); // R4
endmodule

// File: rtl/vi_read_mux.sv
module vi_read_mux
  import vi_irq_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [SRC_W-1:0]  flags,
  input  logic [SRC_W-1:0]  en,
  output logic [DATA_W-1:0] data
);
  logic any_pending;
  assign any_pending = |(flags & en);

  always_comb begin
    unique case (idx)
      IDX_FLAGS:  data = {any_pending, flags};
      IDX_ENABLE: data = {1'b1, en};
      default:    data = '0;
    endcase
  end
endmodule

// File: rtl/vi_irq_ctrl.sv
module vi_irq_ctrl
  import vi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sr_evt,
  input  logic              t1_evt,
  input  logic              t2_evt,
  output logic              irq
);
  logic [IDX_W-1:0]   idx;
  logic [IDX_LSB-1:0] unused_addr_lo;
  logic [SRC_W-1:0]   set_vec, clr_vec;
  logic [SRC_W-1:0]   flags, flags_nxt;
  logic [SRC_W-1:0]   en, en_nxt;
  logic [DATA_W-1:0]  rd_mux;

  assign idx            = addr[IDX_LSB +: IDX_W];
  assign unused_addr_lo = addr[IDX_LSB-1:0];

  always_comb begin
    set_vec         = '0;
    set_vec[BIT_SR] = sr_evt;
    set_vec[BIT_T2] = t2_evt;
    set_vec[BIT_T1] = t1_evt;
  end

  // clearing accesses: flag-register writes plus side-effect reads
  always_comb begin
    clr_vec = '0;
    if (wr_en && idx == IDX_FLAGS) clr_vec = wr_data[SRC_W-1:0];
    if (rd_en && idx == IDX_SHIFT) clr_vec[BIT_SR] = 1'b1;
    if (rd_en && idx == IDX_T1_LO) clr_vec[BIT_T1] = 1'b1;
    if (rd_en && idx == IDX_T2_LO) clr_vec[BIT_T2] = 1'b1;
  end

  vi_flag_bank #(.W(SRC_W)) u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .flags(flags), .flags_nxt(flags_nxt)
  );

  vi_enable_reg #(.DATA_W(DATA_W)) u_enable (
    .clk(clk), .rst(rst), .wr(wr_en && idx == IDX_ENABLE),
    .wr_data(wr_data), .en(en), .en_nxt(en_nxt)
  );

  vi_read_mux u_rmux (
    .idx(idx), .flags(flags), .en(en), .data(rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= rd_en ? rd_mux : '0;
      irq     <= |(flags_nxt & en_nxt & IRQ_MASK);
    end
  end

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == (|(flags & en & IRQ_MASK))); // R7
  AST_EN_READ_MSB: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == IDX_ENABLE) |=> rd_data[DATA_W-1]); // R5
  AST_SUMMARY_BIT: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == IDX_FLAGS) |=> rd_data[DATA_W-1] == $past(|(flags & en))); // R6
  AST_SR_READ_CLR: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == IDX_SHIFT && !sr_evt) |=> !flags[BIT_SR]); // R8
  AST_IDLE_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == '0); // R11
endmodule

// File: tb/vi_irq_ctrl_tb.sv
module vi_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        sr_evt = 1'b0, t1_evt = 1'b0, t2_evt = 1'b0;
  logic        irq;

  always #2.5 clk = ~clk;

  vi_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .sr_evt(sr_evt),
    .t1_evt(t1_evt), .t2_evt(t2_evt), .irq(irq)
  );

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_flag = 0, m_en = 0, exp_rd = 0, exp_irq = 0;

  function automatic logic [12:0] at(input int idx, input int lo = 0);
    return {idx[3:0], lo[8:0]};
  endfunction

  task automatic model_edge(input logic rd, input logic wr, input logic [12:0] a,
                            input logic [7:0] d, input logic s, input logic t1,
                            input logic t2);
    int idx = int'(a[12:9]);
    int clr = 0;
    int set = 0;
    exp_rd = 0;
    if (rd) begin
      if (idx == 13) exp_rd = m_flag | (((m_flag & m_en) != 0) ? 'h80 : 0);
      else if (idx == 14) exp_rd = m_en | 'h80;
    end
    if (wr && idx == 13) clr = clr | int'(d[6:0]);
    if (rd && idx == 10) clr = clr | 'h04;
    if (rd && idx == 4)  clr = clr | 'h40;
    if (rd && idx == 8)  clr = clr | 'h20;
    if (wr && idx == 14) begin
      if (d[7]) m_en = m_en | int'(d[6:0]);
      else      m_en = m_en & ~int'(d[6:0]) & 'h7f;
    end
    set = (s ? 'h04 : 0) | (t2 ? 'h20 : 0) | (t1 ? 'h40 : 0);
    m_flag = ((m_flag & ~clr) | set) & 'h7f;
    exp_irq = ((m_flag & m_en & 'h44) != 0) ? 1 : 0;
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (int'(rd_data) != exp_rd) begin
      miscompares++;
      $display("FAIL %s rd_data actual=%02h expected=%02h", tag, rd_data, exp_rd[7:0]);
    end
    vectors++;
    if (int'(irq) != exp_irq) begin
      miscompares++;
      $display("FAIL %s irq actual=%0d expected=%0d", tag, irq, exp_irq);
    end
  endtask

  task automatic step(input string tag, input logic rd, input logic wr,
                      input logic [12:0] a, input logic [7:0] d,
                      input logic s = 1'b0, input logic t1 = 1'b0,
                      input logic t2 = 1'b0);
    rd_en = rd; wr_en = wr; addr = a; wr_data = d;
    sr_evt = s; t1_evt = t1; t2_evt = t2;
    @(posedge clk);
    model_edge(rd, wr, a, d, s, t1, t2);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R1");
    step("R1", 1'b1, 1'b0, at(13), 8'h00);
    step("R1", 1'b1, 1'b0, at(14), 8'h00);
    // R2 shift source, then R4 set-mode enable, R7 line, R5/R6 reads
    step("R2", 1'b0, 1'b0, '0, '0, 1'b1);
    step("R2", 1'b1, 1'b0, at(13), 8'h00);
    step("R4", 1'b0, 1'b1, at(14), 8'h84);
    step("R7", 1'b1, 1'b0, at(14), 8'h00);
    step("R6", 1'b1, 1'b0, at(13), 8'h00);
    // timer 2 pending and enabled must not hold irq up
    step("R2", 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
    step("R4", 1'b0, 1'b1, at(14), 8'hA0);
    step("R8", 1'b1, 1'b0, at(10), 8'h00);
    step("R7", 1'b1, 1'b0, at(13), 8'h00);
    // clear-mode enable write
    step("R4", 1'b0, 1'b1, at(14), 8'h20);
    step("R6", 1'b1, 1'b0, at(13), 8'h00);
    step("R5", 1'b1, 1'b0, at(14), 8'h00);
    // timer 1 set colliding with its clearing read
    step("R4", 1'b0, 1'b1, at(14), 8'hC0);
    step("R10", 1'b1, 1'b0, at(4), 8'h00, 1'b0, 1'b1);
    step("R10", 1'b1, 1'b0, at(13), 8'h00);
    // partial flag-register write
    step("R2", 1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 1'b1);
    step("R3", 1'b0, 1'b1, at(13), 8'h40);
    step("R3", 1'b1, 1'b0, at(13), 8'h00);
    step("R3", 1'b0, 1'b1, at(13), 8'h00);
    step("R3", 1'b1, 1'b0, at(13), 8'h00);
    // writes to side-effect addresses do not clear
    step("R2", 1'b0, 1'b0, '0, '0, 1'b0, 1'b1);
    step("R8", 1'b0, 1'b1, at(4), 8'hFF);
    step("R8", 1'b0, 1'b1, at(8), 8'hFF);
    step("R8", 1'b0, 1'b1, at(10), 8'hFF);
    step("R8", 1'b1, 1'b0, at(13), 8'h00);
    step("R8", 1'b1, 1'b0, at(8), 8'h00);
    step("R8", 1'b1, 1'b0, at(4), 8'h00);
    step("R8", 1'b1, 1'b0, at(13), 8'h00);
    // set wins over a flag-register write
    step("R10", 1'b0, 1'b1, at(13), 8'h7F, 1'b1);
    step("R10", 1'b1, 1'b0, at(13), 8'h00);
    // low address bits ignored
    step("R9", 1'b1, 1'b0, at(13, 'h1FF), 8'h00);
    step("R9", 1'b0, 1'b1, at(14, 'h155), 8'h04);
    step("R9", 1'b1, 1'b0, at(14, 'h0AA), 8'h00);
    step("R9", 1'b1, 1'b0, at(10, 'h1FF), 8'h00);
    // unowned index and idle cycles read zero
    step("R11", 1'b1, 1'b0, at(0), 8'h00, 1'b1);
    step("R11", 1'b1, 1'b0, at(15), 8'h00);
    idle("R11");
    // random mix of all indices
    for (int n = 0; n < 4000; n++) begin
      int sel = int'($urandom_range(0, 7));
      int idxs[8] = '{0, 4, 5, 8, 10, 13, 14, 15};
      logic op = 1'($urandom_range(0, 1));
      logic act = ($urandom_range(0, 3) != 0);
      step("random", act & op, act & ~op, at(idxs[sel], int'($urandom_range(0, 511))),
           8'($urandom), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule